// File: doc/BRIEF.md
# Serial Memory Sequential Read Master

This block is a clock-divided SPI master that reads a contiguous run of bytes from a serial memory, for example while a loader fetches an image at boot. A one-cycle `start` pulse supplies a start address, a byte count, an address-width selector and a clock divider setting. The block drives chip select low and sends the read opcode 0x03. It then sends one, two or three address bytes and keeps clocking, so the memory streams out the bytes from that address onward. No second command is issued.

Each received byte appears on a valid/ready output port. Only one byte can wait there. If the consumer holds off, the serial clock pauses low at the next byte boundary and chip select stays low, so the memory's sequential read is not broken. When the programmed count has been received, chip select is released and `done` pulses. A count of zero completes at once and never touches the bus.

Top module: `spi_seq_read_master`

## Requirements
- R1: While `rst` is high and in the cycle after it rises, `spi_cs_n`=1, `spi_sck`=0, `spi_mosi`=0, `out_valid`=0 and `done`=0. A reset during a transfer releases chip select.
- R2: The bus runs in SPI mode 0. `spi_sck` is low whenever chip select is high. `spi_mosi` changes only while `spi_sck` is low, so the memory samples it on rising edges.
- R3: After chip select falls, the first byte on `spi_mosi` is the read opcode 0x03, MSB first.
- R4: The opcode is followed by the address, most significant byte first and each byte MSB first. The number of address bytes depends on `addr_sel`: 0 sends one byte (`start_addr[7:0]`), 1 sends two bytes (`start_addr[15:0]`), and 2 or 3 send three bytes (`start_addr[23:0]`).
- R5: Exactly `byte_count` data bytes are delivered, in address order. Each is sampled from `spi_miso` on rising edges, MSB first, within one chip-select assertion and one command.
- R6: `spi_mosi` is 0 throughout the data phase.
- R7: `out_valid` and `out_data` hold until `out_ready` is high. While a byte waits, `spi_sck` stays low before the next data byte and chip select stays low. No byte is lost.
- R8: `done` is a one-cycle pulse, raised once per transfer, with `spi_cs_n` already high.
- R9: A start with `byte_count`=0 raises `done` in the cycle after `start`, and chip select never falls.
- R10: Chip select falls exactly `clk_div`+1 cycles before the first rising edge of `spi_sck`. It rises exactly `clk_div`+1 cycles after the last falling edge.
- R11: During the opcode byte, consecutive rising edges of `spi_sck` are 2×(`clk_div`+1) cycles apart.
- R12: A `start` pulse while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a read |
| start_addr | input | 24 | First memory address; only the selected low bytes are sent |
| byte_count | input | CNT_W | Number of data bytes to read |
| addr_sel | input | 2 | Address width: 0 = one byte, 1 = two bytes, 2 or 3 = three bytes |
| clk_div | input | DIV_W | Half period of the serial clock, minus one, in system cycles |
| out_ready | input | 1 | Consumer accepts `out_data` |
| spi_miso | input | 1 | Serial data from the memory |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the memory |
| out_valid | output | 1 | `out_data` holds a received byte |
| out_data | output | 8 | Received byte |
| done | output | 1 | Transfer complete pulse |

## Verification
The assertions assume that `clk_div`, `start_addr`, `byte_count` and `addr_sel` are only meaningful in the cycle of `start`. They also assume that `spi_miso` changes only while `spi_sck` is low, and that the consumer never withdraws `out_ready` in a way that matters before the handshake edge. The bench keeps to these assumptions. It changes inputs only on falling system-clock edges. Its memory model updates `spi_miso` only on falling serial-clock edges and derives data from the address it actually received. Ready is dropped only while a byte is waiting, and only for a fixed, bounded stall.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  localparam int          ADDR_W     = 24;
  localparam int          BYTE_W     = 8;
  localparam logic [7:0]  RD_OPCODE  = 8'h03;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } seq_state_t;

  // address width selector -> number of address bytes on the wire
  function automatic logic [1:0] addr_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    addr_bytes = 2'd1;
      2'd1:    addr_bytes = 2'd2;
      default: addr_bytes = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/spi_rd_tickgen.sv
module spi_rd_tickgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == half_div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  assign tick = run && (cnt == half_div);

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= half_div));

endmodule

// File: rtl/spi_rd_shifter.sv
module spi_rd_shifter
  import spi_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              active,
  input  logic              hold_first,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic [BYTE_W-1:0] next_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              byte_end,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int BIT_W = $clog2(BYTE_W);

  logic [BIT_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] tx_sr;
  logic [BYTE_W-1:0] rx_sr;
  logic              rise;
  logic              fall;

  // a pending output byte blocks only the first rising edge of a byte
  assign rise     = active && tick && !sck && !(hold_first && (bit_idx == '0));
  assign fall     = active && tick && sck;
  assign byte_end = fall && (bit_idx == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck     <= 1'b0;
      bit_idx <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
    end else if (load) begin
      sck     <= 1'b0;
      bit_idx <= '0;
      tx_sr   <= load_byte;
    end else begin
      if (rise) begin
        sck   <= 1'b1;
        rx_sr <= {rx_sr[BYTE_W-2:0], miso};
      end
      if (fall) begin
        sck     <= 1'b0;
        bit_idx <= bit_idx + BIT_W'(1);
        tx_sr   <= byte_end ? next_byte : {tx_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign mosi    = tx_sr[BYTE_W-1];
  assign rx_byte = rx_sr;

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));

endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq
  import spi_rd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [1:0]        addr_sel,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              tick,
  input  logic              byte_end,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              out_ready,
  output logic              run,
  output logic              active,
  output logic              hold_first,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic [BYTE_W-1:0] next_byte,
  output logic [DIV_W-1:0]  half_div,
  output logic              cs_n,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              done
);

  seq_state_t        state;
  logic [CNT_W-1:0]  data_rem;
  logic [1:0]        hdr_rem;
  logic              in_data;
  logic [ADDR_W-1:0] addr_sr;
  logic [ADDR_W-1:0] aligned;
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        nab;
  logic              accept;

  assign nab    = addr_bytes(addr_sel);
  assign accept = (state == ST_IDLE) && start;

  // left-justify the used address bytes so the next one is always on top
  always_comb begin
    case (nab)
      2'd1:    aligned = {start_addr[7:0], 16'h0000};
      2'd2:    aligned = {start_addr[15:0], 8'h00};
      default: aligned = start_addr;
    endcase
  end

  assign load       = accept && (byte_count != '0);
  assign load_byte  = RD_OPCODE;
  assign next_byte  = (!in_data && (hdr_rem != 2'd0)) ? addr_sr[ADDR_W-1 -: BYTE_W] : '0;
  assign run        = (state != ST_IDLE);
  assign active     = (state == ST_SHIFT);
  assign hold_first = in_data && out_valid && !out_ready;
  assign half_div   = div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      data_rem  <= '0;
      hdr_rem   <= '0;
      in_data   <= 1'b0;
      addr_sr   <= '0;
      div_q     <= '0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (byte_count == '0) begin
              done <= 1'b1;
            end else begin
              state    <= ST_SHIFT;
              cs_n     <= 1'b0;
              div_q    <= clk_div;
              data_rem <= byte_count;
              hdr_rem  <= nab;
              in_data  <= 1'b0;
              addr_sr  <= aligned;
            end
          end
        end
        ST_SHIFT: begin
          if (byte_end) begin
            if (!in_data) begin
              if (hdr_rem != 2'd0) begin
                hdr_rem <= hdr_rem - 2'd1;
                addr_sr <= {addr_sr[ADDR_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
              end else begin
                in_data <= 1'b1;
              end
            end else begin
              out_valid <= 1'b1;
              out_data  <= rx_byte;
              data_rem  <= data_rem - CNT_W'(1);
              if (data_rem == CNT_W'(1)) begin
                state <= ST_TAIL;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state   <= ST_IDLE;
            cs_n    <= 1'b1;
            done    <= 1'b1;
            in_data <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_end && in_data) |-> !out_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_cs_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> cs_n);

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (byte_count == '0)) |=> (done && cs_n));

endmodule

// File: rtl/spi_seq_read_master.sv
module spi_seq_read_master
  import spi_rd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [1:0]        addr_sel,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              out_ready,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              done
);

  logic              tick;
  logic              run;
  logic              active;
  logic              hold_first;
  logic              load;
  logic [BYTE_W-1:0] load_byte;
  logic [BYTE_W-1:0] next_byte;
  logic [DIV_W-1:0]  half_div;
  logic              byte_end;
  logic [BYTE_W-1:0] rx_byte;

  spi_rd_seq #(.CNT_W(CNT_W), .DIV_W(DIV_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .byte_count (byte_count),
    .addr_sel   (addr_sel),
    .clk_div    (clk_div),
    .tick       (tick),
    .byte_end   (byte_end),
    .rx_byte    (rx_byte),
    .out_ready  (out_ready),
    .run        (run),
    .active     (active),
    .hold_first (hold_first),
    .load       (load),
    .load_byte  (load_byte),
    .next_byte  (next_byte),
    .half_div   (half_div),
    .cs_n       (spi_cs_n),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .done       (done)
  );

  spi_rd_tickgen #(.DIV_W(DIV_W)) tick_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .half_div (half_div),
    .tick     (tick)
  );

  spi_rd_shifter shift_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .active     (active),
    .hold_first (hold_first),
    .load       (load),
    .load_byte  (load_byte),
    .next_byte  (next_byte),
    .miso       (spi_miso),
    .sck        (spi_sck),
    .mosi       (spi_mosi),
    .byte_end   (byte_end),
    .rx_byte    (rx_byte)
  );

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  // R10
  cs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> !spi_sck);

endmodule

// File: tb/spi_seq_read_master_tb.sv
module spi_seq_read_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [15:0] byte_count = '0;
  logic [1:0]  addr_sel = '0;
  logic [7:0]  clk_div = '0;
  logic        out_ready = 1'b1;
  logic        spi_miso = 1'b0;
  logic        spi_sck;
  logic        spi_cs_n;
  logic        spi_mosi;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        done;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  spi_seq_read_master dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .addr_sel(addr_sel), .clk_div(clk_div),
    .out_ready(out_ready), .spi_miso(spi_miso), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .out_valid(out_valid),
    .out_data(out_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [7:0] memf(input logic [23:0] a);
    memf = {a[3:0], a[7:4]} ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  // behavioural serial memory
  int          m_nab = 1;
  int          m_bits = 0;
  logic [31:0] m_hdr = '0;
  bit          m_mosi_bad = 0;

  always @(negedge spi_cs_n) begin
    m_bits = 0; m_hdr = '0; m_mosi_bad = 0;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (m_bits < 8*(1+m_nab)) m_hdr = {m_hdr[30:0], spi_mosi};
    else if (spi_mosi) m_mosi_bad = 1;
    m_bits++;
  end

  always @(negedge spi_sck) if (!spi_cs_n && m_bits >= 8*(1+m_nab)) begin
    int idx;
    logic [23:0] mask, a;
    logic [7:0] b;
    idx  = m_bits - 8*(1+m_nab);
    mask = 24'hFFFFFF >> (8*(3-m_nab));
    a    = ((m_hdr[23:0] & mask) + 24'(idx/8)) & mask;
    b    = memf(a);
    spi_miso <= b[7-(idx%8)];
  end

  // bus monitor, samples away from the active edge
  logic sck_prev = 1'b0, cs_prev = 1'b1, mosi_prev = 1'b0;
  int t_csf, t_r1, t_r2, t_lf, t_csr, nrise;
  int done_cnt = 0, csf_cnt = 0;
  bit idle_bad = 0, mosi_bad = 0, done_cs_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cs_prev && !spi_cs_n) begin t_csf = cyc; nrise = 0; csf_cnt++; end
      if (!sck_prev && spi_sck) begin
        nrise++;
        if (nrise == 1) t_r1 = cyc;
        if (nrise == 2) t_r2 = cyc;
      end
      if (sck_prev && !spi_sck) t_lf = cyc;
      if (!cs_prev && spi_cs_n) t_csr = cyc;
      if (done) begin done_cnt++; if (!spi_cs_n) done_cs_bad = 1; end
      if (spi_cs_n && spi_sck) idle_bad = 1;
      if (sck_prev && spi_sck && (spi_mosi != mosi_prev)) mosi_bad = 1;
    end
    sck_prev = spi_sck; cs_prev = spi_cs_n; mosi_prev = spi_mosi;
  end

  initial begin
    wait (cyc >= WDOG);
    nerr++;
    $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WDOG);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  // {addr[39:16], sel[15:14], count[13:6], div[5:2], stall[1], poke[0]}
  localparam logic [39:0] VEC [7] = '{
    {24'h000010, 2'd0, 8'd4, 4'd0, 1'b0, 1'b0},
    {24'h0012FE, 2'd1, 8'd6, 4'd1, 1'b0, 1'b0},
    {24'hABCDEF, 2'd2, 8'd5, 4'd2, 1'b1, 1'b0},
    {24'h3456FF, 2'd0, 8'd3, 4'd0, 1'b1, 1'b0},
    {24'hFFFFFE, 2'd3, 8'd4, 4'd3, 1'b0, 1'b0},
    {24'h00FFFF, 2'd1, 8'd1, 4'd0, 1'b0, 1'b0},
    {24'h102030, 2'd2, 8'd7, 4'd1, 1'b0, 1'b1}
  };

  task automatic run_xfer(input logic [23:0] a, input logic [1:0] sel, input int cnt,
                          input int dv, input bit stall, input bit poke);
    int nab, got, tmo, d0, c0;
    logic [23:0] mask, ea;
    logic [7:0] held;
    bit stall_bad;
    nab  = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 3;
    mask = 24'hFFFFFF >> (8*(3-nab));
    d0 = done_cnt; c0 = csf_cnt;
    idle_bad = 0; mosi_bad = 0; done_cs_bad = 0;
    m_nab = nab;
    @(negedge clk);
    start = 1; start_addr = a; addr_sel = sel; byte_count = 16'(cnt); clk_div = 8'(dv);
    out_ready = 1;
    @(negedge clk);
    start = 0;
    got = 0; tmo = 0;
    while (got < cnt && tmo < 20000) begin
      @(negedge clk); tmo++;
      if (out_valid) begin
        if (stall && (got % 2 == 0)) begin
          out_ready = 0; held = out_data; stall_bad = 0;
          repeat (25) begin
            @(negedge clk);
            if (!out_valid || out_data != held || spi_sck) stall_bad = 1;
            if (got < cnt-1 && spi_cs_n) stall_bad = 1;
          end
          chk(!stall_bad, "R7", $sformatf("stall hold broken at byte %0d, actual 1 expected 0", got));
          out_ready = 1;
        end
        ea = ((a & mask) + 24'(got)) & mask;
        chk(out_data == memf(ea), "R5",
            $sformatf("byte %0d actual %02h expected %02h", got, out_data, memf(ea)));
        got++;
        if (poke && got == 1) begin
          @(negedge clk); start = 1; start_addr = 24'h777777; byte_count = 16'd9;
          @(negedge clk); start = 0;
        end
      end
    end
    chk(got == cnt, "R5", $sformatf("byte count actual %0d expected %0d", got, cnt));
    tmo = 0;
    while (done_cnt == d0 && tmo < 5000) begin @(negedge clk); tmo++; end
    repeat (6) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8", $sformatf("done pulses actual %0d expected 1", done_cnt - d0));
    chk(!done_cs_bad, "R8", "done with cs low, actual 1 expected 0");
    chk(csf_cnt == c0 + 1, "R5", $sformatf("cs assertions actual %0d expected 1", csf_cnt - c0));
    chk(((m_hdr >> (8*nab)) & 32'hFF) == 32'h03, "R3",
        $sformatf("opcode actual %02h expected 03", (m_hdr >> (8*nab)) & 32'hFF));
    chk((m_hdr[23:0] & mask) == (a & mask), "R4",
        $sformatf("address actual %06h expected %06h", m_hdr[23:0] & mask, a & mask));
    chk(!m_mosi_bad, "R6", "mosi high in data phase, actual 1 expected 0");
    chk(!idle_bad && !mosi_bad, "R2",
        $sformatf("mode0 violations actual %0d/%0d expected 0/0", idle_bad, mosi_bad));
    chk(t_r1 - t_csf == dv + 1, "R10",
        $sformatf("cs to first rise actual %0d expected %0d", t_r1 - t_csf, dv + 1));
    chk(t_csr - t_lf == dv + 1, "R10",
        $sformatf("last fall to cs release actual %0d expected %0d", t_csr - t_lf, dv + 1));
    chk(t_r2 - t_r1 == 2*(dv + 1), "R11",
        $sformatf("rise spacing actual %0d expected %0d", t_r2 - t_r1, 2*(dv + 1)));
    if (poke) begin
      c0 = csf_cnt; d0 = done_cnt;
      repeat (40) @(negedge clk);
      chk(csf_cnt == c0 && done_cnt == d0, "R12",
          $sformatf("extra activity after ignored start actual %0d expected 0",
                    csf_cnt - c0 + done_cnt - d0));
    end
  endtask

  initial begin
    int c0, d0;
    // R1: outputs during reset
    repeat (3) begin
      @(negedge clk);
      chk(spi_cs_n && !spi_sck && !spi_mosi && !out_valid && !done, "R1",
          $sformatf("reset outputs cs=%0b sck=%0b mosi=%0b v=%0b d=%0b expected 1,0,0,0,0",
                    spi_cs_n, spi_sck, spi_mosi, out_valid, done));
    end
    rst = 0;
    @(negedge clk);
    chk(spi_cs_n && !spi_sck && !out_valid && !done, "R1", "outputs after reset not idle");

    for (int i = 0; i < 7; i++) begin
      run_xfer(VEC[i][39:16], VEC[i][15:14], int'(VEC[i][13:6]), int'(VEC[i][5:2]),
               VEC[i][1], VEC[i][0]);
    end

    // R9: zero count
    c0 = csf_cnt;
    @(negedge clk); start = 1; byte_count = 16'd0; start_addr = 24'h000100; addr_sel = 2'd1;
    @(negedge clk); start = 0;
    chk(done && spi_cs_n, "R9", $sformatf("zero count done=%0b cs=%0b expected 1,1", done, spi_cs_n));
    @(negedge clk);
    chk(!done, "R9", $sformatf("zero count done length actual %0b expected 0", done));
    repeat (10) @(negedge clk);
    chk(csf_cnt == c0, "R9", $sformatf("cs falls actual %0d expected 0", csf_cnt - c0));

    // R1: reset in the middle of a transfer
    m_nab = 3;
    @(negedge clk); start = 1; byte_count = 16'd8; start_addr = 24'h456789; addr_sel = 2'd2; clk_div = 8'd1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(spi_cs_n && !spi_sck && !out_valid, "R1",
        $sformatf("mid-transfer reset cs=%0b sck=%0b v=%0b expected 1,0,0", spi_cs_n, spi_sck, out_valid));
    rst = 0;
    d0 = done_cnt;
    repeat (20) @(negedge clk);
    chk(spi_cs_n && done_cnt == d0, "R1", "bus not idle after mid-transfer reset");

    // recover with a normal transfer after the abort
    run_xfer(24'h0000AA, 2'd0, 2, 0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule